// File: doc/BRIEF.md
# Sextant Majority Trigger

The block turns 30 chamber multiplicity codes into trigger bits. The chambers form six sextants of five chamber planes each. Each 4-bit multiplicity is compared with one programmable threshold, which gives one hit bit per chamber. Each sextant then runs an x-out-of-5 vote over its planes, and x is programmable. The block exports the 30 chamber bits, the 6 sextant bits and one combined trigger flag to a downstream trigger unit.

Beats enter and leave on valid/ready streams, with a fixed pipeline of two registers. The threshold and the majority setting are sampled together with the beat they apply to. A beat is accepted on any rising edge where `in_valid` and `in_ready` are both high. A beat is delivered on any rising edge where `out_valid` and `out_ready` are both high. While the output is stalled, the whole pipeline freezes and `in_ready` drops. Saturating scalers count delivered beats for each sextant bit and for the combined flag. They can be cleared synchronously.

Top module: `sextant_majority_trigger`

## Requirements
- R1: Chamber c occupies bits [4c+3:4c] of `in_mult`. `out_chamber[c]` is 1 exactly when that multiplicity is strictly greater than `thresh`.
- R2: Chamber c belongs to sextant c/5 as plane c%5. `out_sext[s]` is 1 when the number of set chamber bits among chambers 5s..5s+4 is at least the effective majority.
- R3: A `maj_sel` value of 0 acts as a majority of 1.
- R4: A `maj_sel` value of 6 or 7 means no sextant fires. `out_sext` is then 0 and `out_trig` is 0, whatever the hits.
- R5: `out_trig` is the OR of the six `out_sext` bits of the same beat.
- R6: The pipeline holds no beat and `out_ready` stays high. A beat accepted on rising edge k is then presented with `out_valid` high right after edge k+1, and not before.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low. The output fields and `out_valid` also hold stable until the beat is delivered. Beats leave in the order they were accepted.
- R8: `thresh` and `maj_sel` are sampled on the edge that accepts the beat. A change to either afterwards does not alter that beat.
- R9: Sextant scaler s is bits [32s+31:32s] of `scaler_sext`. It increases by one on each delivered beat whose `out_sext[s]` is 1. `scaler_trig` does the same for `out_trig`.
- R10: A scaler at its all-ones value stays there.
- R11: `scaler_clr` high on an edge sets every scaler to 0, and this wins over an increment. After reset the scalers are 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| in_mult | input | 120 | 30 chamber multiplicities, 4 bits each |
| thresh | input | 4 | Multiplicity threshold |
| maj_sel | input | 3 | Required planes per sextant |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_chamber | output | 30 | Per-chamber hit bits |
| out_sext | output | 6 | Per-sextant majority bits |
| out_trig | output | 1 | Combined trigger flag |
| scaler_clr | input | 1 | Synchronous clear of all scalers |
| scaler_sext | output | 192 | Six sextant scalers, 32 bits each |
| scaler_trig | output | 32 | Combined trigger scaler |

## Verification
The assertions assume that `out_ready` is a plain level that the downstream may change on any cycle. They also assume that `scaler_clr` can arrive at any time, and that the inputs carry known values once reset is released. Beyond that they assume nothing about the input stream: the sextant and flag checks hold for any multiplicity pattern and any majority setting. The stimulus keeps every input at a defined value from time zero. It changes inputs only at falling edges, or one time unit after a rising edge. It throttles `out_ready` pseudo-randomly so that the stall rules are exercised with both short and long stalls.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int unsigned SEXTANTS_DEF = 6;
  localparam int unsigned PLANES_DEF   = 5;
  localparam int unsigned MULT_W_DEF   = 4;
  localparam int unsigned SCALER_W_DEF = 32;

  // decoded form of the majority setting
  typedef enum logic [1:0] {
    VOTE_AT_LEAST = 2'd0,
    VOTE_DISABLED = 2'd1
  } vote_mode_e;
endpackage

// File: rtl/smt_chamber_cmp.sv
module smt_chamber_cmp #(
  parameter int unsigned N_CH   = 30,
  parameter int unsigned MULT_W = 4
) (
  input  logic [N_CH*MULT_W-1:0] mult,
  input  logic [MULT_W-1:0]      thresh,
  output logic [N_CH-1:0]        hits
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // strict comparison: equal to threshold is not a hit
    assign hits[c] = mult[c*MULT_W +: MULT_W] > thresh;
  end
endmodule

// File: rtl/smt_sextant_vote.sv
module smt_sextant_vote #(
  parameter int unsigned N_PLANE = 5,
  parameter int unsigned MAJ_W   = 3
) (
  input  logic [N_PLANE-1:0] hits,
  input  logic [MAJ_W-1:0]   need,
  input  smt_pkg::vote_mode_e mode,
  output logic               fire
);
  logic [MAJ_W-1:0] tally;

  always_comb begin
    tally = '0;
    for (int p = 0; p < N_PLANE; p++) begin
      tally = tally + MAJ_W'(hits[p]);
    end
    fire = (mode == smt_pkg::VOTE_AT_LEAST) && (tally >= need);
  end
endmodule

// File: rtl/smt_sat_counter.sv
module smt_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
    end else if (inc && (count != {W{1'b1}})) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sextant_majority_trigger.sv
module sextant_majority_trigger #(
  parameter int unsigned N_SEXT  = smt_pkg::SEXTANTS_DEF,
  parameter int unsigned N_PLANE = smt_pkg::PLANES_DEF,
  parameter int unsigned MULT_W  = smt_pkg::MULT_W_DEF,
  parameter int unsigned CNT_W   = smt_pkg::SCALER_W_DEF,
  localparam int unsigned N_CH   = N_SEXT * N_PLANE,
  localparam int unsigned MAJ_W  = $clog2(N_PLANE + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_CH*MULT_W-1:0]   in_mult,
  input  logic [MULT_W-1:0]        thresh,
  input  logic [MAJ_W-1:0]         maj_sel,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [N_CH-1:0]          out_chamber,
  output logic [N_SEXT-1:0]        out_sext,
  output logic                     out_trig,
  input  logic                     scaler_clr,
  output logic [N_SEXT*CNT_W-1:0]  scaler_sext,
  output logic [CNT_W-1:0]         scaler_trig
);
  import smt_pkg::*;

  // global advance: the pipeline moves unless the output beat is stuck
  logic advance;
  logic accept;
  logic deliver;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;
  assign deliver  = out_valid && out_ready;

  // ---------------- stage 1: threshold compare, config capture
  logic [N_CH-1:0] hits_c;
  logic [MAJ_W-1:0] need_c;
  vote_mode_e       mode_c;

  smt_chamber_cmp #(.N_CH(N_CH), .MULT_W(MULT_W)) u_cmp (
    .mult   (in_mult),
    .thresh (thresh),
    .hits   (hits_c)
  );

  always_comb begin
    need_c = (maj_sel == '0) ? MAJ_W'(1) : maj_sel;
    mode_c = (maj_sel > MAJ_W'(N_PLANE)) ? VOTE_DISABLED : VOTE_AT_LEAST;
  end

  logic             s1_valid;
  logic [N_CH-1:0]  s1_hits;
  logic [MAJ_W-1:0] s1_need;
  vote_mode_e       s1_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hits  <= '0;
      s1_need  <= MAJ_W'(1);
      s1_mode  <= VOTE_DISABLED;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (accept) begin
        s1_hits <= hits_c;
        s1_need <= need_c;
        s1_mode <= mode_c;
      end
    end
  end

  // ---------------- stage 2: majority vote per sextant
  logic [N_SEXT-1:0] fire_c;

  for (genvar s = 0; s < N_SEXT; s++) begin : g_sext
    smt_sextant_vote #(.N_PLANE(N_PLANE), .MAJ_W(MAJ_W)) u_vote (
      .hits (s1_hits[s*N_PLANE +: N_PLANE]),
      .need (s1_need),
      .mode (s1_mode),
      .fire (fire_c[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_chamber <= '0;
      out_sext    <= '0;
      out_trig    <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_chamber <= s1_hits;
        out_sext    <= fire_c;
        out_trig    <= |fire_c;
      end
    end
  end

  // ---------------- scalers, counting delivered beats
  for (genvar s = 0; s < N_SEXT; s++) begin : g_scl
    smt_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (scaler_clr),
      .inc   (deliver && out_sext[s]),
      .count (scaler_sext[s*CNT_W +: CNT_W])
    );
  end

  smt_sat_counter #(.W(CNT_W)) u_cnt_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (scaler_clr),
    .inc   (deliver && out_trig),
    .count (scaler_trig)
  );
endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
  parameter int unsigned N_SEXT  = 6,
  parameter int unsigned N_PLANE = 5,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned N_CH   = N_SEXT * N_PLANE
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [N_CH-1:0]         out_chamber,
  input logic [N_SEXT-1:0]       out_sext,
  input logic                    out_trig,
  input logic                    scaler_clr,
  input logic [N_SEXT*CNT_W-1:0] scaler_sext,
  input logic [CNT_W-1:0]        scaler_trig
);
  assert_stall_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_chamber) && $stable(out_sext) && $stable(out_trig)));

  assert_flag_is_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trig == (out_sext != '0)));

  for (genvar s = 0; s < N_SEXT; s++) begin : g_chk
    // a firing sextant must have at least one hit plane
    assert_sext_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sext[s]) |-> ($countones(out_chamber[s*N_PLANE +: N_PLANE]) >= 1));
  end

  assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    scaler_clr |=> ((scaler_trig == '0) && (scaler_sext == '0)));

  assert_trig_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((scaler_trig == {CNT_W{1'b1}}) && !scaler_clr) |=> (scaler_trig == {CNT_W{1'b1}}));

  assert_trig_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !scaler_clr |=> (scaler_trig >= $past(scaler_trig)));
endmodule

bind sextant_majority_trigger smt_checker #(
  .N_SEXT  (N_SEXT),
  .N_PLANE (N_PLANE),
  .CNT_W   (CNT_W)
) u_smt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_chamber (out_chamber),
  .out_sext    (out_sext),
  .out_trig    (out_trig),
  .scaler_clr  (scaler_clr),
  .scaler_sext (scaler_sext),
  .scaler_trig (scaler_trig)
);

// File: tb/sextant_majority_trigger_tb_top.sv
`timescale 1ns/1ps
module sextant_majority_trigger_tb_top;
  localparam int NS = 6;
  localparam int NP = 5;
  localparam int NC = NS * NP;
  localparam int MW = 4;
  localparam int CW = 4;  // narrow scalers so saturation is reachable
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NC*MW-1:0] in_mult = '0;
  logic [MW-1:0] thresh = '0;
  logic [2:0] maj_sel = 3'd1;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NC-1:0] out_chamber;
  logic [NS-1:0] out_sext;
  logic out_trig;
  logic scaler_clr = 1'b0;
  logic [NS*CW-1:0] scaler_sext;
  logic [CW-1:0] scaler_trig;

  always #2 clk = ~clk;  // 250 MHz

  sextant_majority_trigger #(.N_SEXT(NS), .N_PLANE(NP), .MULT_W(MW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mult(in_mult), .thresh(thresh), .maj_sel(maj_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_chamber(out_chamber),
    .out_sext(out_sext), .out_trig(out_trig), .scaler_clr(scaler_clr),
    .scaler_sext(scaler_sext), .scaler_trig(scaler_trig)
  );

  int checks = 0;
  int fails  = 0;
  logic [NC+NS:0] expq[$];
  logic [CW-1:0] m_sext[NS];
  logic [CW-1:0] m_trig;
  logic bp_en = 1'b0;
  logic [NC*MW-1:0] mv;

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected beat straight from R1..R5: {chamber, sext, trig}
  function automatic logic [NC+NS:0] model(input logic [NC*MW-1:0] m, input logic [MW-1:0] t, input logic [2:0] x);
    logic [NC-1:0] ch;
    logic [NS-1:0] sx;
    int need;
    for (int c = 0; c < NC; c++) ch[c] = (m[c*MW +: MW] > t);
    need = (x == 0) ? 1 : int'(x);
    for (int s = 0; s < NS; s++) begin
      int n = 0;
      for (int p = 0; p < NP; p++) n += int'(ch[s*NP+p]);
      sx[s] = (x <= 5) && (n >= need);
    end
    return {ch, sx, |sx};
  endfunction

  task automatic send(input logic [NC*MW-1:0] m, input logic [MW-1:0] t, input logic [2:0] x);
    @(negedge clk);
    in_mult = m; thresh = t; maj_sel = x; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    expq.push_back(model(m, t, x));
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    // R8: disturb config after acceptance
    thresh = ~thresh; maj_sel = 3'd6;
  endtask

  task automatic drain();
    while (expq.size() != 0 || out_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_scalers(input string tag);
    drain();
    for (int s = 0; s < NS; s++)
      check(scaler_sext[s*CW +: CW] == m_sext[s], tag, scaler_sext[s*CW +: CW], m_sext[s]);
    check(scaler_trig == m_trig, tag, scaler_trig, m_trig);
  endtask

  // downstream throttle, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    out_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor: scoreboard compare, stall stability, scaler model
  logic stalled_q = 1'b0;
  logic [NC+NS:0] snap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled_q) begin
        check(out_valid && ({out_chamber, out_sext, out_trig} == snap), "R7 hold",
              {out_valid, out_chamber, out_sext, out_trig}, {1'b1, snap});
      end
      if (out_valid && !out_ready) begin
        check(!in_ready, "R7 in_ready", in_ready, 0);
      end
      stalled_q = out_valid && !out_ready;
      snap = {out_chamber, out_sext, out_trig};
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7 extra beat", {out_chamber, out_sext, out_trig}, 0);
        end else begin
          logic [NC+NS:0] e;
          e = expq.pop_front();
          check({out_chamber, out_sext, out_trig} == e, "R1/R2/R5 beat",
                {out_chamber, out_sext, out_trig}, e);
          for (int s = 0; s < NS; s++)
            if (e[1+s] && m_sext[s] != CMAX) m_sext[s]++;
          if (e[0] && m_trig != CMAX) m_trig++;
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) m_sext[s] = '0;
    m_trig = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!out_valid && in_ready, "R11 reset handshake", {out_valid, in_ready}, 2'b01);
    check(scaler_trig == '0 && scaler_sext == '0, "R11 reset scalers", scaler_trig, 0);

    // R1: all above threshold, majority 5
    mv = '0;
    for (int c = 0; c < NC; c++) mv[c*MW +: MW] = 4'd1;
    send(mv, 4'd0, 3'd5);
    // R1 strict: equal to threshold gives no hit
    send(mv, 4'd1, 3'd1);
    // R1: threshold 7, only 8 counts
    mv = '0;
    for (int c = 0; c < NC; c++) mv[c*MW +: MW] = (c % 2 == 0) ? 4'd8 : 4'd7;
    send(mv, 4'd7, 3'd3);
    // R3: majority 0 acts as 1, single hit in sextant 2 plane 4
    mv = '0; mv[14*MW +: MW] = 4'd15;
    send(mv, 4'd0, 3'd0);
    send(mv, 4'd0, 3'd1);
    // R4: disabled settings, all chambers hit
    for (int c = 0; c < NC; c++) mv[c*MW +: MW] = 4'd15;
    send(mv, 4'd0, 3'd6);
    send(mv, 4'd0, 3'd7);
    // R2: majority 3, sextant 0 has 2 hits, sextant 1 has 3
    mv = '0;
    mv[0*MW +: MW] = 4'd9; mv[4*MW +: MW] = 4'd9;
    mv[5*MW +: MW] = 4'd9; mv[7*MW +: MW] = 4'd9; mv[9*MW +: MW] = 4'd9;
    send(mv, 4'd4, 3'd3);
    idle();
    check_scalers("R9 scalers directed");

    // R6 latency: accepted edge k, valid only after edge k+1
    send(mv, 4'd4, 3'd2);
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid, "R6 not before k+1", out_valid, 0);
    @(negedge clk);
    check(out_valid, "R6 valid after k+1", out_valid, 1);
    drain();

    // R7/R8 random traffic under back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [NC*MW-1:0] r;
      for (int c = 0; c < NC; c++) r[c*MW +: MW] = MW'($urandom);
      send(r, MW'($urandom % 12), 3'($urandom % 8));
      if (i % 37 == 0) idle();
    end
    idle();
    bp_en = 1'b0;
    check_scalers("R10 saturation");

    // R11 clear wins over increments
    @(negedge clk);
    scaler_clr = 1'b1;
    for (int s = 0; s < NS; s++) m_sext[s] = '0;
    m_trig = '0;
    @(negedge clk);
    scaler_clr = 1'b0;
    check(scaler_trig == '0 && scaler_sext == '0, "R11 clear", scaler_trig, 0);
    for (int c = 0; c < NC; c++) mv[c*MW +: MW] = 4'd3;
    send(mv, 4'd2, 3'd5);
    send(mv, 4'd2, 3'd4);
    idle();
    check_scalers("R9 after clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule